// File: doc/BRIEF.md
# Microcoded Stack-Bytecode Core

This block is a small multicycle processor core. It runs a four-opcode stack bytecode: push a local variable, pop into a local variable, add the two top words, and push a sign-extended byte constant. Bytecode comes from a byte-wide program ROM, addressed by the program counter. One dispatch cycle decodes each opcode and jumps into a microprogram. The microprogram runs for a fixed number of cycles and then returns to dispatch. An operand byte is read from the ROM in the same way.

Each microinstruction selects one B-bus source with a 4-bit binary code. It names its destinations with a one-bit-per-register bitmap, so one ALU result can land in several registers in a single cycle. Locals and the operand stack share one word-wide RAM. That RAM has registered read data: a read issued in one cycle returns its data in the next. A free-running cycle counter lets the per-opcode costs be measured from outside. Any opcode outside the set stops the core until reset.

Top module: `stack_core`

## Requirements
- R1: While reset is held low, `halt` is 0, `cycle_count` is 0, `rom_addr` is 0 and `mem_we` is 0.
- R2: Opcode 0x04 followed by an immediate byte pushes that byte sign-extended to 32 bits. It costs 4 cycles, counting dispatch.
- R3: Opcode 0x01 followed by an unsigned index byte pushes the RAM word at LV_INIT + index. It costs 6 cycles.
- R4: Opcode 0x03 pops the top two words and pushes their sum modulo 2^32. It costs 4 cycles.
- R5: Opcode 0x02 followed by an unsigned index byte pops the top word into RAM address LV_INIT + index. It costs 7 cycles.
- R6: The sequence load, load, add, store completes in exactly 23 cycles.
- R7: Two orders give the same stored result j+m+8. The first is: load j, load m, push 8, add, add, store. The second is: load j, load m, add, push 8, add, store.
- R8: An opcode outside {0x01..0x04} raises `halt` in the cycle after its dispatch. `halt` stays high until reset. While halted there is no RAM access, `rom_addr` stays on the faulting opcode, and `cycle_count` is frozen.
- R9: The stack grows upward from SP_INIT. A push writes address SP+1, so the first push goes to SP_INIT+1. A pop reads the word below the old top, so stores happen in last-in, first-out order.
- R10: `cycle_count` rises by one on every clock edge while not halted. After a program ends in a bad opcode, it equals the sum of the opcode costs plus 1.
- R11: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts execution at ROM address 0 |
| rom_addr | output | PCW | Program ROM byte address (program counter) |
| rom_data | input | 8 | Program ROM byte at `rom_addr`, combinational |
| mem_addr | output | AW | Word address for the locals/stack RAM |
| mem_re | output | 1 | Read request; data is expected on `mem_rdata` one cycle later |
| mem_we | output | 1 | Write strobe, taken at the clock edge |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Registered read data |
| halt | output | 1 | Sticky stop flag for an unrecognised opcode |
| cycle_count | output | CW | Count of running cycles since reset |

## Verification
The hardest case to reach from the ports is the point where the cached top-of-stack register has to agree with RAM across mixed push and pop traffic. Examples are an add right after a byte push, or a store that empties the stack down to one word. The bench gets there with seeded random programs that track legal stack depth. It only issues an add at depth two or more and a store at depth one or more, and it compares every local and every live stack slot against a bench-side stack model. Directed programs add the two add orders, sign and wrap edges, and the frozen state after a fault.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;
  localparam int DW     = 32;
  localparam int UPC_W  = 5;
  localparam int NCREG  = 7;
  // destination bitmap positions
  localparam int C_MAR = 0;
  localparam int C_MDR = 1;
  localparam int C_PC  = 2;
  localparam int C_SP  = 3;
  localparam int C_LV  = 4;
  localparam int C_TOS = 5;
  localparam int C_H   = 6;

  localparam logic [NCREG-1:0] M_MAR = NCREG'(1) << C_MAR;
  localparam logic [NCREG-1:0] M_MDR = NCREG'(1) << C_MDR;
  localparam logic [NCREG-1:0] M_PC  = NCREG'(1) << C_PC;
  localparam logic [NCREG-1:0] M_SP  = NCREG'(1) << C_SP;
  localparam logic [NCREG-1:0] M_TOS = NCREG'(1) << C_TOS;
  localparam logic [NCREG-1:0] M_H   = NCREG'(1) << C_H;

  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_ADD   = 8'h03;
  localparam logic [7:0] OP_PUSHB = 8'h04;

  typedef enum logic [3:0] {
    BS_MDR = 4'd0, BS_PC = 4'd1, BS_MBR = 4'd2, BS_MBRU = 4'd3,
    BS_SP = 4'd4, BS_LV = 4'd5, BS_TOS = 4'd6, BS_NONE = 4'd15
  } bsel_e;

  typedef enum logic [1:0] {ALU_B, ALU_ADD, ALU_INC, ALU_DEC} alu_e;

  typedef struct packed {
    logic [UPC_W-1:0] nxt;
    logic             jam;    // next address from opcode
    alu_e             alu;
    logic [NCREG-1:0] cmask;  // one bit per destination
    bsel_e            bsel;   // binary source select
    logic             rd;
    logic             wr;
    logic             fetch;
  } uinstr_t;

  function automatic logic [DW-1:0] alu_f(alu_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_INC: return b + DW'(1);
      ALU_DEC: return b - DW'(1);
      default: return b;
    endcase
  endfunction

  function automatic logic [DW-1:0] sext8(logic [7:0] v);
    return {{(DW-8){v[7]}}, v};
  endfunction

  function automatic uinstr_t mk_u(logic [UPC_W-1:0] nxt, logic jam, alu_e alu,
                                   logic [NCREG-1:0] cm, bsel_e bs,
                                   logic rd, logic wr, logic f);
    uinstr_t u;
    u.nxt = nxt; u.jam = jam; u.alu = alu; u.cmask = cm;
    u.bsel = bs; u.rd = rd; u.wr = wr; u.fetch = f;
    return u;
  endfunction

  // microstore: each routine ends by returning to address 0 (dispatch)
  function automatic uinstr_t ustore(logic [UPC_W-1:0] a);
    case (a)
      5'd0:  return mk_u(5'd0,  1'b1, ALU_INC, M_PC,         BS_PC,   1'b0, 1'b0, 1'b0);
      // load local: 5 steps
      5'd1:  return mk_u(5'd2,  1'b0, ALU_B,   M_H,          BS_LV,   1'b0, 1'b0, 1'b1);
      5'd2:  return mk_u(5'd3,  1'b0, ALU_ADD, M_MAR,        BS_MBRU, 1'b1, 1'b0, 1'b0);
      5'd3:  return mk_u(5'd4,  1'b0, ALU_INC, M_PC,         BS_PC,   1'b0, 1'b0, 1'b0);
      5'd4:  return mk_u(5'd5,  1'b0, ALU_INC, M_MAR | M_SP, BS_SP,   1'b0, 1'b1, 1'b0);
      5'd5:  return mk_u(5'd0,  1'b0, ALU_B,   M_TOS,        BS_MDR,  1'b0, 1'b0, 1'b0);
      // store local: 6 steps
      5'd6:  return mk_u(5'd7,  1'b0, ALU_B,   M_H,          BS_LV,   1'b0, 1'b0, 1'b1);
      5'd7:  return mk_u(5'd8,  1'b0, ALU_ADD, M_MAR,        BS_MBRU, 1'b0, 1'b0, 1'b0);
      5'd8:  return mk_u(5'd9,  1'b0, ALU_B,   M_MDR,        BS_TOS,  1'b0, 1'b1, 1'b0);
      5'd9:  return mk_u(5'd10, 1'b0, ALU_DEC, M_MAR | M_SP, BS_SP,   1'b1, 1'b0, 1'b0);
      5'd10: return mk_u(5'd11, 1'b0, ALU_INC, M_PC,         BS_PC,   1'b0, 1'b0, 1'b0);
      5'd11: return mk_u(5'd0,  1'b0, ALU_B,   M_TOS,        BS_MDR,  1'b0, 1'b0, 1'b0);
      // add: 3 steps
      5'd12: return mk_u(5'd13, 1'b0, ALU_DEC, M_MAR | M_SP, BS_SP,   1'b1, 1'b0, 1'b0);
      5'd13: return mk_u(5'd14, 1'b0, ALU_B,   M_H,          BS_TOS,  1'b0, 1'b0, 1'b0);
      5'd14: return mk_u(5'd0,  1'b0, ALU_ADD, M_MDR | M_TOS, BS_MDR, 1'b0, 1'b1, 1'b0);
      // push byte: 3 steps
      5'd15: return mk_u(5'd16, 1'b0, ALU_INC, M_MAR | M_SP, BS_SP,   1'b0, 1'b0, 1'b1);
      5'd16: return mk_u(5'd17, 1'b0, ALU_INC, M_PC,         BS_PC,   1'b0, 1'b0, 1'b0);
      5'd17: return mk_u(5'd0,  1'b0, ALU_B,   M_MDR | M_TOS, BS_MBR, 1'b0, 1'b1, 1'b0);
      default: return mk_u(5'd0, 1'b0, ALU_B, '0, BS_NONE, 1'b0, 1'b0, 1'b0);
    endcase
  endfunction

  // {valid, entry address}
  function automatic logic [UPC_W:0] entry(logic [7:0] op);
    case (op)
      OP_LOAD:  return {1'b1, 5'd1};
      OP_STORE: return {1'b1, 5'd6};
      OP_ADD:   return {1'b1, 5'd12};
      OP_PUSHB: return {1'b1, 5'd15};
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/stack_core_ctrl.sv
module stack_core_ctrl
  import stack_core_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             opcode,
  output uinstr_t                uop,
  output logic                   go,
  output logic                   halt,
  output logic                   disp_fire,
  output logic [CW-1:0]          cyc
);
  logic [UPC_W-1:0] upc_q;
  logic             halt_q;
  logic [UPC_W:0]   ent;
  logic             bad_op;

  assign uop       = ustore(upc_q);
  assign ent       = entry(opcode);
  assign bad_op    = uop.jam && !ent[UPC_W];
  assign go        = !halt_q && !bad_op;
  assign disp_fire = !halt_q && uop.jam && ent[UPC_W];
  assign halt      = halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      halt_q <= 1'b0;
      cyc    <= '0;
    end else if (!halt_q) begin
      cyc <= cyc + CW'(1);
      if (bad_op)       halt_q <= 1'b1;
      else if (uop.jam) upc_q  <= ent[UPC_W-1:0];
      else              upc_q  <= uop.nxt;
    end
  end
endmodule

// File: rtl/stack_core_dp.sv
module stack_core_dp
  import stack_core_pkg::*;
#(
  parameter int AW      = 10,
  parameter int PCW     = 8,
  parameter int SP_INIT = 255,
  parameter int LV_INIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  uinstr_t         uop,
  input  logic [7:0]      rom_data,
  input  logic [DW-1:0]   mem_rdata,
  output logic [PCW-1:0]  rom_addr,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   sp_o
);
  logic [DW-1:0] creg [NCREG];
  logic [7:0]    mbr_q;
  logic          rd_pend_q;
  logic [DW-1:0] bbus, cbus, mar_nx, mdr_nx;
  logic          unused_hi;

  function automatic logic [DW-1:0] init_val(int i);
    if (i == C_SP) return DW'(SP_INIT);
    if (i == C_LV) return DW'(LV_INIT);
    return '0;
  endfunction

  always_comb begin
    case (uop.bsel)
      BS_MDR:  bbus = creg[C_MDR];
      BS_PC:   bbus = creg[C_PC];
      BS_MBR:  bbus = sext8(mbr_q);
      BS_MBRU: bbus = {{(DW-8){1'b0}}, mbr_q};
      BS_SP:   bbus = creg[C_SP];
      BS_LV:   bbus = creg[C_LV];
      BS_TOS:  bbus = creg[C_TOS];
      default: bbus = '0;
    endcase
  end

  assign cbus = alu_f(uop.alu, creg[C_H], bbus);

  // memory operations see the values written in the same step
  assign mar_nx    = (go && uop.cmask[C_MAR]) ? cbus : creg[C_MAR];
  assign mdr_nx    = (go && uop.cmask[C_MDR]) ? cbus : creg[C_MDR];
  assign mem_addr  = mar_nx[AW-1:0];
  assign mem_wdata = mdr_nx;
  assign mem_re    = go && uop.rd;
  assign mem_we    = go && uop.wr;
  assign rom_addr  = creg[C_PC][PCW-1:0];
  assign sp_o      = creg[C_SP];
  assign unused_hi = ^{mar_nx[DW-1:AW], creg[C_PC][DW-1:PCW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCREG; i++) creg[i] <= init_val(i);
      mbr_q     <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCREG; i++) begin
        if (go && uop.cmask[i])            creg[i] <= cbus;
        else if (i == C_MDR && rd_pend_q)  creg[i] <= mem_rdata;
      end
      if (go && uop.fetch) mbr_q <= rom_data;
      rd_pend_q <= go && uop.rd;
    end
  end
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stack_core_pkg::*;
#(
  parameter int AW      = 10,
  parameter int PCW     = 8,
  parameter int CW      = 32,
  parameter int SP_INIT = 255,
  parameter int LV_INIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PCW-1:0]  rom_addr,
  input  logic [7:0]      rom_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            halt,
  output logic [CW-1:0]   cycle_count
);
  uinstr_t       uop;
  logic          go;
  logic          disp_fire;
  logic [DW-1:0] sp_now;

  stack_core_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(rom_data), .uop(uop), .go(go),
    .halt(halt), .disp_fire(disp_fire), .cyc(cycle_count)
  );

  stack_core_dp #(.AW(AW), .PCW(PCW), .SP_INIT(SP_INIT), .LV_INIT(LV_INIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .go(go), .uop(uop), .rom_data(rom_data),
    .mem_rdata(mem_rdata), .rom_addr(rom_addr), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .sp_o(sp_now)
  );
endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
  parameter int PCW = 8,
  parameter int CW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           halt,
  input logic           mem_re,
  input logic           mem_we,
  input logic [PCW-1:0] rom_addr,
  input logic [CW-1:0]  cycle_count,
  input logic           disp_fire,
  input logic [31:0]    sp_now
);
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mem_re && !mem_we));
  a_r8_rom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(rom_addr));
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> (cycle_count == CW'($past(cycle_count) + 1)));
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cycle_count));
  a_r11_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  a_r9_sp_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> ((sp_now == $past(sp_now)) || (sp_now == $past(sp_now) + 32'd1)
               || (sp_now == $past(sp_now) - 32'd1)));
  a_r6_dispatch_advances_pc: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (rom_addr == PCW'($past(rom_addr) + 1)));
endmodule

bind stack_core stack_core_chk #(.PCW(PCW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .mem_re(mem_re), .mem_we(mem_we),
  .rom_addr(rom_addr), .cycle_count(cycle_count), .disp_fire(disp_fire),
  .sp_now(sp_now)
);

// File: tb/sim_stack_core.sv
module sim_stack_core;
  localparam int SP0 = 255;
  localparam int LV0 = 0;
  localparam logic [7:0] T_LOAD = 8'h01, T_STORE = 8'h02, T_ADD = 8'h03, T_PUSH = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rom_addr, rom_data;
  logic [9:0]  mem_addr;
  logic        mem_re, mem_we, halt;
  logic [31:0] mem_wdata, mem_rdata, rd_q;
  logic [31:0] cycle_count;

  logic [7:0]  rom [256];
  logic [31:0] ram [1024];
  logic [31:0] mstk [64];
  logic [31:0] mloc [16];
  int depth, plen, exp_cyc, checks, fails, both_cnt;
  bit done;

  always #5 clk = ~clk;

  stack_core u0 (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .halt(halt), .cycle_count(cycle_count)
  );

  assign rom_data  = rom[rom_addr];
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    rd_q <= ram[mem_addr];
  end
  always @(negedge clk) if (rst_n && mem_re && mem_we) both_cnt++;

  function automatic logic [31:0] sx(logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction
  function automatic int cost(logic [7:0] op);
    case (op)
      T_LOAD: return 6; T_STORE: return 7; T_ADD: return 4; default: return 4;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic new_prog();
    plen = 0; depth = 0; exp_cyc = 0;
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;
    for (int i = 0; i < 16; i++) begin
      mloc[i] = $urandom;
      ram[LV0 + i] <= mloc[i];
    end
  endtask
  task automatic set_loc(int i, logic [31:0] v);
    mloc[i] = v; ram[LV0 + i] <= v;
  endtask
  task automatic e_push(logic [7:0] b);
    rom[plen] = T_PUSH; rom[plen+1] = b; plen += 2;
    mstk[depth] = sx(b); depth++; exp_cyc += cost(T_PUSH);
  endtask
  task automatic e_load(int i);
    rom[plen] = T_LOAD; rom[plen+1] = 8'(i); plen += 2;
    mstk[depth] = mloc[i]; depth++; exp_cyc += cost(T_LOAD);
  endtask
  task automatic e_add();
    rom[plen] = T_ADD; plen += 1;
    mstk[depth-2] = mstk[depth-2] + mstk[depth-1]; depth--; exp_cyc += cost(T_ADD);
  endtask
  task automatic e_store(int i);
    rom[plen] = T_STORE; rom[plen+1] = 8'(i); plen += 2;
    mloc[i] = mstk[depth-1]; depth--; exp_cyc += cost(T_STORE);
  endtask

  task automatic run_prog(string req);
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halt && n < 4000) begin @(negedge clk); n++; end
    chk(req, "halted", {31'd0, halt}, 32'd1);
  endtask

  task automatic check_state(string req);
    chk(req, "cycles", cycle_count, 32'(exp_cyc + 1));
    for (int i = 0; i < 16; i++) chk(req, "local", ram[LV0 + i], mloc[i]);
    for (int i = 0; i < depth; i++) chk(req, "stack", ram[SP0 + 1 + i], mstk[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cc, j, m;
    logic [7:0]  ra;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) ram[i] <= 32'd0;
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;
    rd_q = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "halt", {31'd0, halt}, 32'd0);
    chk("R1", "cycle_count", cycle_count, 32'd0);
    chk("R1", "rom_addr", {24'd0, rom_addr}, 32'd0);
    chk("R1", "mem_we", {31'd0, mem_we}, 32'd0);

    // R2 sign extension, both signs
    new_prog(); e_push(8'h80); e_push(8'h7F); run_prog("R2"); check_state("R2");
    new_prog(); e_push(8'hFF); run_prog("R2"); chk("R2", "cost", cycle_count, 32'd5);
    // R3 load cost and value
    new_prog(); set_loc(3, 32'h1234_5678); e_load(3); run_prog("R3");
    chk("R3", "cost", cycle_count, 32'd7); check_state("R3");
    // R4 add and wrap
    new_prog(); e_push(8'd5); e_push(8'hFD); e_add(); run_prog("R4"); check_state("R4");
    chk("R4", "sum", ram[SP0 + 1], 32'd2);
    new_prog(); set_loc(0, 32'hFFFF_FFFF); set_loc(1, 32'd1); e_load(0); e_load(1); e_add();
    run_prog("R4"); chk("R4", "wrap", ram[SP0 + 1], 32'd0);
    chk("R4", "cost", cycle_count, 32'd6 + 32'd6 + 32'd4 + 32'd1);
    // R5 store
    new_prog(); e_push(8'd9); e_store(7); run_prog("R5");
    chk("R5", "cost", cycle_count, 32'd12); chk("R5", "local7", ram[LV0 + 7], 32'd9);
    // R6 load, load, add, store = 23
    new_prog(); e_load(2); e_load(5); e_add(); e_store(9); run_prog("R6");
    chk("R6", "cycles", cycle_count, 32'd24); check_state("R6");
    // R7 two orders
    new_prog(); j = mloc[1]; m = mloc[2];
    e_load(1); e_load(2); e_push(8'd8); e_add(); e_add(); e_store(4); run_prog("R7");
    chk("R7", "order_a", ram[LV0 + 4], j + m + 32'd8);
    new_prog(); set_loc(1, j); set_loc(2, m);
    e_load(1); e_load(2); e_add(); e_push(8'd8); e_add(); e_store(4); run_prog("R7");
    chk("R7", "order_b", ram[LV0 + 4], j + m + 32'd8);
    // R9 LIFO pops
    new_prog(); e_push(8'd1); e_push(8'd2); e_push(8'd3); e_store(0); e_store(1);
    run_prog("R9"); check_state("R9");
    chk("R9", "first_slot", ram[SP0 + 1], 32'd1);
    chk("R9", "pop_order", ram[LV0 + 0], 32'd3);
    // R8 halt is sticky and quiet
    new_prog(); e_push(8'd4); run_prog("R8");
    chk("R8", "fault_pc", {24'd0, rom_addr}, 32'(plen));
    cc = cycle_count; ra = rom_addr; both_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_we || mem_re) both_cnt += 100;
    end
    chk("R8", "no_access", 32'(both_cnt), 32'd0);
    chk("R8", "count_frozen", cycle_count, cc);
    chk("R8", "pc_frozen", {24'd0, rom_addr}, {24'd0, ra});
    chk("R8", "still_halted", {31'd0, halt}, 32'd1);

    // R10 random programs against the stack model
    both_cnt = 0;
    for (int p = 0; p < 30; p++) begin
      new_prog();
      for (int k = 0; k < 14; k++) begin
        int r;
        r = int'($urandom % 4);
        if (r == 2 && depth < 2) r = 0;
        if (r == 3 && depth < 1) r = 1;
        if (depth > 40 && r < 2) r = 3;
        case (r)
          0: e_push(8'($urandom));
          1: e_load(int'($urandom % 16));
          2: e_add();
          default: e_store(int'($urandom % 16));
        endcase
      end
      run_prog("R10");
      check_state("R10");
    end
    // R11 port exclusivity over all random runs
    chk("R11", "rd_wr_overlap", 32'(both_cnt), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule